// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block holds the per-interrupt bookkeeping of a small interrupt distributor. Each interrupt keeps an enable bit, a pending latch, an active bit, a recorded line level and a group bit for every target CPU. It also keeps one trigger-mode bit that covers all CPUs. Hardware lines come in one per interrupt and CPU, through a registered sampling stage. A single-cycle write port lets software set or clear each per-CPU field for the CPUs named in a mask, and program the trigger mode. A completion strobe models the end of handling for one interrupt.

A combinational query port takes an interrupt number and a CPU mask. It returns the effective pending status and the other state for that pair. A mode input chooses between the two semantics. In generic semantics, a level-triggered interrupt counts as pending while its line is high, whatever the latch holds. In legacy semantics, only the latch counts, and it is refreshed from the line when the interrupt completes.

Top module: `irq_pend_tracker`

## Requirements
- R1: With `generic_mode`=1, `q_pending` is 1 when, for some CPU in `q_mask`, the pending latch is set, or the interrupt is level-triggered and its recorded level is high. The level term is never used for an edge-triggered interrupt.
- R2: With `generic_mode`=0, `q_pending` reflects the pending latch alone over `q_mask`, whatever the recorded level is.
- R3: Line `irq_lines[i*NUM_CPU+c]` belongs to interrupt i and CPU c. The recorded level follows the line two clocks later. In generic mode a rising line sets the latch only if the interrupt is edge-triggered.
- R4: A falling line clears only the recorded level and leaves the pending latch unchanged.
- R5: `wr_op`=4 (pending clear) clears only the latch for the CPUs in `wr_mask`. A level-triggered interrupt in generic mode whose line is still high keeps reporting pending.
- R6: `wr_op`=3 (pending set) sets the latch for the CPUs in `wr_mask`. The latch stays set after the line falls, until a pending clear.
- R7: Every set or clear acts only on the CPUs named in `wr_mask`. The query outputs OR the selected field over the CPUs in `q_mask`.
- R8: In legacy mode a rising line sets the latch for that CPU, for both trigger modes.
- R9: A completion (`cmpl_en`) of a level-triggered interrupt in legacy mode sets the latch for each CPU in `cmpl_mask` whose recorded level is high. In generic mode a completion changes nothing.
- R10: When a hardware latch set and a software pending clear reach the same interrupt and CPU on the same clock, the latch ends up set.
- R11: Reset (`rst` high at a clock edge) clears all state: disabled, not pending, not active, level-triggered, group 0.
- R12: The `wr_op` codes are: 1 enable set, 2 enable clear, 5 active set, 6 active clear, 8 group set, 9 group clear, and 7 trigger write (`wr_val` 1 = edge, 0 = level). These show on `q_enabled`, `q_active`, `q_group` and `q_edge` one clock after the write. Any other code changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| generic_mode | input | 1 | 1 = generic semantics, 0 = legacy semantics |
| irq_lines | input | NUM_IRQ*NUM_CPU | Hardware lines, one per interrupt and CPU |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 4 | Write operation code |
| wr_irq | input | $clog2(NUM_IRQ) | Interrupt targeted by the write |
| wr_mask | input | NUM_CPU | CPUs the write acts on |
| wr_val | input | 1 | Trigger value for the trigger write |
| cmpl_en | input | 1 | Completion strobe |
| cmpl_irq | input | $clog2(NUM_IRQ) | Interrupt being completed |
| cmpl_mask | input | NUM_CPU | CPUs completing it |
| q_irq | input | $clog2(NUM_IRQ) | Interrupt to query |
| q_mask | input | NUM_CPU | CPUs to query |
| q_pending | output | 1 | Effective pending over q_mask |
| q_enabled | output | 1 | Enable over q_mask |
| q_active | output | 1 | Active over q_mask |
| q_group | output | 1 | Group over q_mask |
| q_edge | output | 1 | Trigger mode of q_irq (1 = edge) |

## Verification
The assertions expect `wr_irq` and `q_irq` to stay below NUM_IRQ. They also expect every input to be stable and known at each clock edge, so the pending-set and enable-clear properties can index state with the values sampled on the previous clock. The bench drives every input on falling edges, uses only legal interrupt numbers, and holds each write strobe for exactly one clock. It also waits out the two-stage line path before it reads the query port. The same-cycle collision is produced on purpose, by placing a pending clear on the clock where a sampled rising edge lands.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_EN_SET = 4'd1,
    OP_EN_CLR = 4'd2,
    OP_PSET   = 4'd3,
    OP_PCLR   = 4'd4,
    OP_ACT_SET= 4'd5,
    OP_ACT_CLR= 4'd6,
    OP_TRIG   = 4'd7,
    OP_GRP_SET= 4'd8,
    OP_GRP_CLR= 4'd9
  } op_e;
endpackage

// File: rtl/irqst_sampler.sv
module irqst_sampler #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lines_in,
  output logic [WIDTH-1:0] lines_q
);
  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= lines_in;
  end
endmodule

// File: rtl/irqst_cell.sv
module irqst_cell
  import irqst_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               generic,
  input  logic               wsel,
  input  logic [3:0]         op,
  input  logic [NUM_CPU-1:0] wmask,
  input  logic               wval,
  input  logic               csel,
  input  logic [NUM_CPU-1:0] cmask,
  input  logic [NUM_CPU-1:0] samp,
  output logic [NUM_CPU-1:0] en_q,
  output logic [NUM_CPU-1:0] pend_q,
  output logic [NUM_CPU-1:0] act_q,
  output logic [NUM_CPU-1:0] lvl_q,
  output logic [NUM_CPU-1:0] grp_q,
  output logic               edge_q
);
  logic [NUM_CPU-1:0] en_n, act_n, grp_n, sw_set, sw_clr;
  logic [NUM_CPU-1:0] rise, hw_set, resample;
  logic               edge_n;

  // Software side
  always_comb begin
    en_n   = en_q;
    act_n  = act_q;
    grp_n  = grp_q;
    edge_n = edge_q;
    sw_set = '0;
    sw_clr = '0;
    if (wsel) begin
      case (op)
        OP_EN_SET:  en_n   = en_q | wmask;
        OP_EN_CLR:  en_n   = en_q & ~wmask;
        OP_PSET:    sw_set = wmask;
        OP_PCLR:    sw_clr = wmask;
        OP_ACT_SET: act_n  = act_q | wmask;
        OP_ACT_CLR: act_n  = act_q & ~wmask;
        OP_TRIG:    edge_n = wval;
        OP_GRP_SET: grp_n  = grp_q | wmask;
        OP_GRP_CLR: grp_n  = grp_q & ~wmask;
        default: ;
      endcase
    end
  end

  // Hardware side: edge seen once, comparing new sample with recorded level
  assign rise     = samp & ~lvl_q;
  assign resample = (csel && !generic && !edge_q) ? (lvl_q & cmask) : '0;
  assign hw_set   = (rise & {NUM_CPU{!generic || edge_q}}) | resample;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      lvl_q  <= '0;
      grp_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      act_q  <= act_n;
      grp_q  <= grp_n;
      edge_q <= edge_n;
      lvl_q  <= samp;
      pend_q <= ((pend_q & ~sw_clr) | sw_set) | hw_set;
    end
  end
endmodule

// File: rtl/irqst_query.sv
module irqst_query #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 4,
  localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
  input  logic                            generic,
  input  logic [IRQ_W-1:0]                q_irq,
  input  logic [NUM_CPU-1:0]              q_mask,
  input  logic [NUM_IRQ-1:0][NUM_CPU-1:0] en_st,
  input  logic [NUM_IRQ-1:0][NUM_CPU-1:0] pend_st,
  input  logic [NUM_IRQ-1:0][NUM_CPU-1:0] act_st,
  input  logic [NUM_IRQ-1:0][NUM_CPU-1:0] lvl_st,
  input  logic [NUM_IRQ-1:0][NUM_CPU-1:0] grp_st,
  input  logic [NUM_IRQ-1:0]              trig_st,
  output logic                            q_pending,
  output logic                            q_enabled,
  output logic                            q_active,
  output logic                            q_group,
  output logic                            q_edge
);
  logic [NUM_CPU-1:0] eff;
  logic               lvl_counts;

  assign lvl_counts = generic && !trig_st[q_irq];
  assign eff        = pend_st[q_irq] | (lvl_st[q_irq] & {NUM_CPU{lvl_counts}});
  assign q_pending  = |(eff & q_mask);
  assign q_enabled  = |(en_st[q_irq] & q_mask);
  assign q_active   = |(act_st[q_irq] & q_mask);
  assign q_group    = |(grp_st[q_irq] & q_mask);
  assign q_edge     = trig_st[q_irq];
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 4,
  localparam int IRQ_W  = $clog2(NUM_IRQ),
  localparam int LINES  = NUM_IRQ * NUM_CPU
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               generic_mode,
  input  logic [LINES-1:0]   irq_lines,
  input  logic               wr_en,
  input  logic [3:0]         wr_op,
  input  logic [IRQ_W-1:0]   wr_irq,
  input  logic [NUM_CPU-1:0] wr_mask,
  input  logic               wr_val,
  input  logic               cmpl_en,
  input  logic [IRQ_W-1:0]   cmpl_irq,
  input  logic [NUM_CPU-1:0] cmpl_mask,
  input  logic [IRQ_W-1:0]   q_irq,
  input  logic [NUM_CPU-1:0] q_mask,
  output logic               q_pending,
  output logic               q_enabled,
  output logic               q_active,
  output logic               q_group,
  output logic               q_edge
);
  logic [LINES-1:0]                samp;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0] en_st, pend_st, act_st, lvl_st, grp_st;
  logic [NUM_IRQ-1:0]              trig_st;

  irqst_sampler #(.WIDTH(LINES)) u_samp (
    .clk(clk), .rst(rst), .lines_in(irq_lines), .lines_q(samp)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    irqst_cell #(.NUM_CPU(NUM_CPU)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .generic(generic_mode),
      .wsel   (wr_en && (wr_irq == IRQ_W'(i))),
      .op     (wr_op),
      .wmask  (wr_mask),
      .wval   (wr_val),
      .csel   (cmpl_en && (cmpl_irq == IRQ_W'(i))),
      .cmask  (cmpl_mask),
      .samp   (samp[i*NUM_CPU +: NUM_CPU]),
      .en_q   (en_st[i]),
      .pend_q (pend_st[i]),
      .act_q  (act_st[i]),
      .lvl_q  (lvl_st[i]),
      .grp_q  (grp_st[i]),
      .edge_q (trig_st[i])
    );
  end

  irqst_query #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_query (
    .generic  (generic_mode),
    .q_irq    (q_irq),
    .q_mask   (q_mask),
    .en_st    (en_st),
    .pend_st  (pend_st),
    .act_st   (act_st),
    .lvl_st   (lvl_st),
    .grp_st   (grp_st),
    .trig_st  (trig_st),
    .q_pending(q_pending),
    .q_enabled(q_enabled),
    .q_active (q_active),
    .q_group  (q_group),
    .q_edge   (q_edge)
  );
endmodule

// File: rtl/irqst_chk.sv
module irqst_chk
  import irqst_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 4,
  localparam int IRQ_W  = $clog2(NUM_IRQ),
  localparam int LINES  = NUM_IRQ * NUM_CPU
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            generic_mode,
  input logic                            wr_en,
  input logic [3:0]                      wr_op,
  input logic [IRQ_W-1:0]                wr_irq,
  input logic [NUM_CPU-1:0]              wr_mask,
  input logic [IRQ_W-1:0]                q_irq,
  input logic [NUM_CPU-1:0]              q_mask,
  input logic                            q_pending,
  input logic [LINES-1:0]                samp,
  input logic [NUM_IRQ-1:0][NUM_CPU-1:0] en_st,
  input logic [NUM_IRQ-1:0][NUM_CPU-1:0] pend_st,
  input logic [NUM_IRQ-1:0][NUM_CPU-1:0] act_st,
  input logic [NUM_IRQ-1:0][NUM_CPU-1:0] lvl_st,
  input logic [NUM_IRQ-1:0][NUM_CPU-1:0] grp_st,
  input logic [NUM_IRQ-1:0]              trig_st
);
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (en_st == '0 && pend_st == '0 && act_st == '0 &&
             lvl_st == '0 && grp_st == '0 && trig_st == '0));

  assert_level_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lvl_st == $past(samp)));

  assert_pend_set_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == OP_PSET) |=>
      ((pend_st[$past(wr_irq)] & $past(wr_mask)) == $past(wr_mask)));

  assert_latch_sw_clear_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|($past(pend_st) & ~pend_st))) |->
      $past(wr_en && wr_op == OP_PCLR));

  assert_en_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == OP_EN_CLR) |=>
      ((en_st[$past(wr_irq)] & $past(wr_mask)) == '0));

  assert_legacy_latch_R2: assert property (@(posedge clk) disable iff (rst)
    !generic_mode |-> (q_pending == (|(pend_st[q_irq] & q_mask))));
endmodule

bind irq_pend_tracker irqst_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst(rst), .generic_mode(generic_mode),
  .wr_en(wr_en), .wr_op(wr_op), .wr_irq(wr_irq), .wr_mask(wr_mask),
  .q_irq(q_irq), .q_mask(q_mask), .q_pending(q_pending), .samp(samp),
  .en_st(en_st), .pend_st(pend_st), .act_st(act_st), .lvl_st(lvl_st),
  .grp_st(grp_st), .trig_st(trig_st)
);

// File: tb/sim_irq_pend_tracker.sv
`timescale 1ns/1ps
module sim_irq_pend_tracker;
  localparam int NI = 16;
  localparam int NC = 4;
  localparam int IW = $clog2(NI);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic generic_mode = 1'b1;
  logic [NI*NC-1:0] irq_lines = '0;
  logic wr_en = 1'b0, wr_val = 1'b0, cmpl_en = 1'b0;
  logic [3:0] wr_op = '0;
  logic [IW-1:0] wr_irq = '0, cmpl_irq = '0, q_irq = '0;
  logic [NC-1:0] wr_mask = '0, cmpl_mask = '0, q_mask = '0;
  logic q_pending, q_enabled, q_active, q_group, q_edge;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_pend_tracker #(.NUM_IRQ(NI), .NUM_CPU(NC)) u0 (
    .clk(clk), .rst(rst), .generic_mode(generic_mode), .irq_lines(irq_lines),
    .wr_en(wr_en), .wr_op(wr_op), .wr_irq(wr_irq), .wr_mask(wr_mask),
    .wr_val(wr_val), .cmpl_en(cmpl_en), .cmpl_irq(cmpl_irq),
    .cmpl_mask(cmpl_mask), .q_irq(q_irq), .q_mask(q_mask),
    .q_pending(q_pending), .q_enabled(q_enabled), .q_active(q_active),
    .q_group(q_group), .q_edge(q_edge)
  );

  // entry: {mode, act, op, irq, mask, val, qmask, exp}
  // act: 0 idle, 1 write, 2 drive lines of irq for mask to val, 3 completion
  localparam int NV = 25;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 2'd2, 4'd0, 4'd3, 4'b0001, 1'b1, 4'b0001, 1'b1}, // R1 R3 level high
    {1'b1, 2'd1, 4'd4, 4'd3, 4'b0001, 1'b0, 4'b0001, 1'b1}, // R5 clear cannot cancel
    {1'b1, 2'd0, 4'd0, 4'd3, 4'b0000, 1'b0, 4'b0010, 1'b0}, // R7 other cpu
    {1'b1, 2'd2, 4'd0, 4'd3, 4'b0001, 1'b0, 4'b0001, 1'b0}, // R3 R4 no latch from level
    {1'b1, 2'd1, 4'd3, 4'd3, 4'b0011, 1'b0, 4'b0010, 1'b1}, // R6 R7
    {1'b1, 2'd2, 4'd0, 4'd3, 4'b0001, 1'b1, 4'b0001, 1'b1},
    {1'b1, 2'd2, 4'd0, 4'd3, 4'b0001, 1'b0, 4'b0001, 1'b1}, // R6 outlives line
    {1'b1, 2'd1, 4'd4, 4'd3, 4'b0001, 1'b0, 4'b0001, 1'b0}, // R7 cpu0 only
    {1'b1, 2'd0, 4'd0, 4'd3, 4'b0000, 1'b0, 4'b0010, 1'b1}, // R7 cpu1 kept
    {1'b1, 2'd1, 4'd4, 4'd3, 4'b0010, 1'b0, 4'b0010, 1'b0},
    {1'b1, 2'd1, 4'd7, 4'd5, 4'b0000, 1'b1, 4'b0100, 1'b0}, // R12 edge mode
    {1'b1, 2'd2, 4'd0, 4'd5, 4'b0100, 1'b1, 4'b0100, 1'b1}, // R3 edge latches
    {1'b1, 2'd2, 4'd0, 4'd5, 4'b0100, 1'b0, 4'b0100, 1'b1}, // R4 fall keeps latch
    {1'b1, 2'd1, 4'd4, 4'd5, 4'b0100, 1'b0, 4'b0100, 1'b0},
    {1'b1, 2'd2, 4'd0, 4'd5, 4'b0100, 1'b1, 4'b0100, 1'b1},
    {1'b1, 2'd1, 4'd4, 4'd5, 4'b0100, 1'b0, 4'b0100, 1'b0}, // R1 edge ignores level
    {1'b1, 2'd2, 4'd0, 4'd9, 4'b0001, 1'b1, 4'b0001, 1'b1},
    {1'b1, 2'd3, 4'd0, 4'd9, 4'b0001, 1'b0, 4'b0001, 1'b1},
    {1'b1, 2'd2, 4'd0, 4'd9, 4'b0001, 1'b0, 4'b0001, 1'b0}, // R9 generic completion inert
    {1'b0, 2'd2, 4'd0, 4'd7, 4'b0001, 1'b1, 4'b0001, 1'b1}, // R8 legacy rise latches
    {1'b0, 2'd1, 4'd4, 4'd7, 4'b0001, 1'b0, 4'b0001, 1'b0}, // R2 latch only
    {1'b0, 2'd3, 4'd0, 4'd7, 4'b0001, 1'b0, 4'b0001, 1'b1}, // R9 resample
    {1'b0, 2'd2, 4'd0, 4'd7, 4'b0001, 1'b0, 4'b0001, 1'b1},
    {1'b0, 2'd1, 4'd4, 4'd7, 4'b0001, 1'b0, 4'b0001, 1'b0},
    {1'b0, 2'd3, 4'd0, 4'd7, 4'b0001, 1'b0, 4'b0001, 1'b0}  // R9 low line no resample
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] op, input int irq,
                          input logic [NC-1:0] m, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_irq = IW'(irq); wr_mask = m; wr_val = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic query(input int irq, input logic [NC-1:0] m);
    q_irq = IW'(irq); q_mask = m; #0.5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    query(0, 4'hF);
    check("R11", q_pending | q_enabled | q_active | q_group | q_edge, 1'b0);
    query(15, 4'hF);
    check("R11", q_pending | q_enabled | q_active | q_group | q_edge, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [20:0] e;
      e = VEC[k];
      @(negedge clk);
      generic_mode = e[20];
      case (e[19:18])
        2'd1: begin
          wr_en = 1'b1; wr_op = e[17:14]; wr_irq = IW'(e[13:10]);
          wr_mask = e[9:6]; wr_val = e[5];
        end
        2'd2: begin
          for (int c = 0; c < NC; c++)
            if (e[6+c]) irq_lines[int'(e[13:10])*NC+c] = e[5];
        end
        2'd3: begin
          cmpl_en = 1'b1; cmpl_irq = IW'(e[13:10]); cmpl_mask = e[9:6];
        end
        default: ;
      endcase
      @(negedge clk);
      wr_en = 1'b0; cmpl_en = 1'b0;
      repeat (2) @(negedge clk);
      query(int'(e[13:10]), e[4:1]);
      check($sformatf("vector %0d (R1..)", k), q_pending, e[0]);
    end

    // R12 enable / active / group and trigger readback, R7 mask
    generic_mode = 1'b1;
    do_write(4'd1, 2, 4'b1010, 1'b0);
    query(2, 4'b0010); check("R12 enable set", q_enabled, 1'b1);
    query(2, 4'b0101); check("R7 enable mask", q_enabled, 1'b0);
    do_write(4'd2, 2, 4'b0010, 1'b0);
    query(2, 4'b0010); check("R12 enable clear", q_enabled, 1'b0);
    query(2, 4'b1000); check("R12 enable kept", q_enabled, 1'b1);
    do_write(4'd5, 2, 4'b0001, 1'b0);
    query(2, 4'b0001); check("R12 active set", q_active, 1'b1);
    do_write(4'd6, 2, 4'b0001, 1'b0);
    check("R12 active clear", q_active, 1'b0);
    do_write(4'd8, 2, 4'b0100, 1'b0);
    query(2, 4'b0100); check("R12 group set", q_group, 1'b1);
    do_write(4'd9, 2, 4'b0100, 1'b0);
    check("R12 group clear", q_group, 1'b0);
    do_write(4'd12, 2, 4'b1111, 1'b1);
    query(2, 4'b1111);
    check("R12 unused code", q_enabled & ~q_active & ~q_group & ~q_edge & ~q_pending, 1'b1);
    do_write(4'd7, 11, 4'b0000, 1'b1);
    query(11, 4'b0001); check("R12 trigger edge", q_edge, 1'b1);

    // R10 hardware set collides with software clear
    @(negedge clk);
    irq_lines[11*NC] = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_op = 4'd4; wr_irq = IW'(11); wr_mask = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0;
    query(11, 4'b0001); check("R10 hw wins", q_pending, 1'b1);

    // R11 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    irq_lines = '0;
    query(11, 4'b0001);
    check("R11 pending", q_pending, 1'b0);
    check("R11 trigger", q_edge, 1'b0);
    query(2, 4'b1000); check("R11 enable", q_enabled, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule